// File: doc/BRIEF.md
# Audio Transmit Sample Buffer

This block sits between a processor register port and the sample input of a serial audio codec link. Software writes 32-bit words to a data address. Each word becomes one or two 20-bit samples, left-justified according to the configured sample width. In the two-per-word packed mode, the low half of the word is stored first. The samples go into a parameterised FIFO.

Once enough samples have accumulated, the FIFO hands them to the codec as stereo pairs over a valid/ready port. The even entry is the left sample and the odd entry is the right sample. Status flags are kept for empty, half-empty, full and underrun, and these drive three interrupt sources. A mask register gates the sources onto a single interrupt line.

Writes use a small address map:
- Address 0 is the transmit control word.
- Address 1 is the sample data port.
- Address 2 is the interrupt enable mask.
- Address 3 is the interrupt clear register.
- Address 4 is the interface control register.

Top module: `aud_tx_fifo`

## Requirements
- R1: The control word (address 0) holds the following fields:
  - bit 0 is transmit enable.
  - bit 1 selects slot 3 and bit 2 selects slot 4.
  - bits 4:3 are the width code: 0 means 16 bits, 1 means 18 bits, 2 means 20 bits and 3 means 12 bits.
  - bit 5 selects packed mode.

  In unpacked mode each data word yields one sample: the word shifted left by 4, 2, 0 or 8 for 16, 18, 20 or 12 bits, then truncated to 20 bits.
- R2: In packed mode a data word yields two samples. The low 16-bit half is stored first, then the high half. Each half is shifted left by 8 for 12-bit width, and by 4 otherwise.
- R3: Packed mode is ignored when the 18-bit or 20-bit width is selected; the words are then handled as unpacked.
- R4: An unpacked write is stored only if level < DEPTH. Otherwise the write is discarded.
- R5: A packed write is stored only if level + 2 < DEPTH (strict). Otherwise both samples are discarded.
- R6: A drain starts only when all of the following hold: transmit enable is set, slot 3 or slot 4 is selected, and level >= DEPTH/2.
- R7: Pairs leave in write order, at most one pair per cycle, with the left sample on `smp_left` and the right sample on `smp_right`. A drain continues while the codec accepts pairs and at least two samples remain.
- R8: After a data write, the flags update as follows:
  - a nonzero level clears empty and underrun.
  - level >= DEPTH/2 clears half-empty.
  - level >= DEPTH sets full.
- R9: After a pair leaves, the flags update as follows:
  - full clears.
  - level <= DEPTH/2 sets half-empty.
  - level 0 sets both empty and underrun.
- R10: The `int_stat` vector has three bits:
  - bit 0 is the underrun flag.
  - bit 1 is the half-empty flag.
  - bit 2 is set when the FIFO is empty and no pair is being offered.

  `irq` is high when any `int_stat` bit whose enable bit (address 2, same positions) is set is high.
- R11: Writing bit 0 = 1 to address 3 clears the underrun flag.
- R12: Two events return the block to its initial state: the reset, and a write of bit 0 = 0 to address 4. In that state the FIFO is empty, the control word and enable mask are zero, empty and half-empty are set, and full and underrun are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| smp_valid | output | 1 | Stereo pair offered to codec |
| smp_ready | input | 1 | Codec accepts the offered pair |
| smp_left | output | SW | Left sample (even FIFO entry) |
| smp_right | output | SW | Right sample (odd FIFO entry) |
| st_empty | output | 1 | FIFO empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_under | output | 1 | Underrun flag |
| int_stat | output | 3 | Raw interrupt status |
| irq | output | 1 | Masked interrupt line |

## Verification
A wrong level count shows up in two ways. A push that should be refused changes the pair sequence, because an extra or missing sample slides every later left/right assignment by one entry. The flags also change from the expected pattern in the cycle after the faulty write. A wrong read pointer or packing order shows on `smp_left` and `smp_right` in the first cycle a pair is offered. A wrong start threshold shows as `smp_valid` rising one write early or late. Flag and mask errors reach `int_stat` and `irq` in the cycle after the push, drain or clear that caused them.

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int SW    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [SW-1:0] smp_left,
  output logic [SW-1:0] smp_right,
  output logic          st_empty,
  output logic          st_half,
  output logic          st_full,
  output logic          st_under,
  output logic [2:0]    int_stat,
  output logic          irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level, lvl_push, lvl_fin;
  logic          txen, sl3, sl4, packed_m, burst;
  logic [1:0]    wsel;
  logic [2:0]    ie;
  logic          e_n, h_n, f_n, u_n;

  wire wr_ctl   = wr_en && wr_addr == 3'd0;
  wire wr_dat   = wr_en && wr_addr == 3'd1;
  wire wr_ie    = wr_en && wr_addr == 3'd2;
  wire wr_clr   = wr_en && wr_addr == 3'd3;
  wire soft_rst = wr_en && wr_addr == 3'd4 && !wr_data[0];

  wire acc_one = wr_dat && !packed_m && (int'(level) < DEPTH);
  wire acc_two = wr_dat &&  packed_m && (int'(level) + 2 < DEPTH);
  wire pop     = smp_valid && smp_ready;

  function automatic logic [SW-1:0] pad_word(input logic [DW-1:0] w, input logic [1:0] s);
    logic [DW+7:0] x;
    case (s)
      2'd0:    x = {8'b0, w} << 4;
      2'd1:    x = {8'b0, w} << 2;
      2'd2:    x = {8'b0, w};
      default: x = {8'b0, w} << 8;
    endcase
    return x[SW-1:0];
  endfunction

  function automatic logic [SW-1:0] pad_half(input logic [15:0] h, input logic [1:0] s);
    logic [23:0] x;
    x = (s == 2'd3) ? {h, 8'b0} : {4'b0, h, 4'b0};
    return x[SW-1:0];
  endfunction

  assign lvl_push  = level + (acc_one ? LW'(1) : acc_two ? LW'(2) : LW'(0));
  assign lvl_fin   = lvl_push - (pop ? LW'(2) : LW'(0));
  assign smp_valid = txen && (sl3 || sl4) &&
                     (burst ? (int'(level) >= 2) : (int'(level) >= HALF));
  assign smp_left  = mem[rp];
  assign smp_right = mem[rp + AW'(1)];
  assign int_stat  = {st_empty && !smp_valid, st_half, st_under};
  assign irq       = |(int_stat & ie);

  always_ff @(posedge clk) begin
    if (acc_one) mem[wp] <= pad_word(wr_data, wsel);
    if (acc_two) begin
      mem[wp]          <= pad_half(wr_data[15:0], wsel);
      mem[wp + AW'(1)] <= pad_half(wr_data[31:16], wsel);
    end
  end

  always_comb begin
    e_n = st_empty; h_n = st_half; f_n = st_full; u_n = st_under;
    if (wr_dat) begin
      if (lvl_push != '0) begin e_n = 1'b0; u_n = 1'b0; end
      if (int'(lvl_push) >= HALF)  h_n = 1'b0;
      if (int'(lvl_push) >= DEPTH) f_n = 1'b1;
    end
    if (pop) begin
      f_n = 1'b0;
      if (int'(lvl_fin) <= HALF) h_n = 1'b1;
      if (lvl_fin == '0) begin e_n = 1'b1; u_n = 1'b1; end
    end
    if (wr_clr && wr_data[0]) u_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0; burst <= 1'b0;
      txen <= 1'b0; sl3 <= 1'b0; sl4 <= 1'b0; packed_m <= 1'b0; wsel <= 2'd0; ie <= 3'd0;
      st_empty <= 1'b1; st_half <= 1'b1; st_full <= 1'b0; st_under <= 1'b0;
    end else if (soft_rst) begin
      wp <= '0; rp <= '0; level <= '0; burst <= 1'b0;
      txen <= 1'b0; sl3 <= 1'b0; sl4 <= 1'b0; packed_m <= 1'b0; wsel <= 2'd0; ie <= 3'd0;
      st_empty <= 1'b1; st_half <= 1'b1; st_full <= 1'b0; st_under <= 1'b0;
    end else begin
      if (wr_ctl) begin
        txen     <= wr_data[0];
        sl3      <= wr_data[1];
        sl4      <= wr_data[2];
        wsel     <= wr_data[4:3];
        packed_m <= wr_data[5] && !(wr_data[4:3] == 2'd1 || wr_data[4:3] == 2'd2);
      end
      if (wr_ie) ie <= wr_data[2:0];
      if (acc_one) wp <= wp + AW'(1);
      if (acc_two) wp <= wp + AW'(2);
      if (pop)     rp <= rp + AW'(2);
      level    <= lvl_fin;
      burst    <= pop;
      st_empty <= e_n; st_half <= h_n; st_full <= f_n; st_under <= u_n;
    end
  end

  // R4
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) int'(level) <= DEPTH);
  // R8
  full_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n) st_full == (int'(level) == DEPTH));
  // R9
  empty_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n) st_empty == (level == '0));
  // R6
  valid_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |-> int'(level) >= 2);
  // R7
  pop_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !wr_dat && !soft_rst) |=> level == $past(level) - LW'(2));
  // R11
  under_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wr_data[0]) |=> !st_under);
endmodule

// File: tb/sim_aud_tx_fifo.sv
`timescale 1ns/1ps
module sim_aud_tx_fifo;
  logic clk = 0, rst_n = 0, wr_en = 0, smp_ready = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic smp_valid, st_empty, st_half, st_full, st_under, irq;
  logic [19:0] smp_left, smp_right;
  logic [2:0] int_stat;
  int checks = 0, errors = 0;
  int cap_n = 0;
  logic [19:0] cap_l [256];
  logic [19:0] cap_r [256];

  aud_tx_fifo u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .st_empty(st_empty), .st_half(st_half), .st_full(st_full), .st_under(st_under),
    .int_stat(int_stat), .irq(irq));

  always #10 clk = ~clk;

  always @(negedge clk) if (smp_valid && smp_ready) begin
    cap_l[cap_n % 256] = smp_left;
    cap_r[cap_n % 256] = smp_right;
    cap_n = cap_n + 1;
  end

  typedef struct packed {
    logic [5:0] ctl; logic [31:0] w0; logic [31:0] w1; logic [2:0] n; logic [19:0] l; logic [19:0] r;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{6'd0,  32'h0000ABCD, 32'hFFFF1234, 3'd4, 20'hABCD0, 20'h12340},
    '{6'd8,  32'h0003FFFF, 32'h00012345, 3'd4, 20'hFFFFC, 20'h48D14},
    '{6'd16, 32'hFFFABCDE, 32'h00054321, 3'd4, 20'hABCDE, 20'h54321},
    '{6'd24, 32'h00000ABC, 32'h00012345, 3'd4, 20'hABC00, 20'h34500},
    '{6'd32, 32'h56781234, 32'h00000000, 3'd2, 20'h12340, 20'h56780},
    '{6'd56, 32'h0DEF0ABC, 32'h00000000, 3'd2, 20'hABC00, 20'hDEF00},
    '{6'd40, 32'h00010001, 32'h00000002, 3'd4, 20'h40004, 20'h00008}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #5; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #5; wr_en = 0;
  endtask

  task automatic restart();
    wr(3'd4, 0); wr(3'd4, 1);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #5; smp_ready = v;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    chk("R12 empty", st_empty, 1); chk("R12 half", st_half, 1);
    chk("R12 full", st_full, 0);   chk("R12 under", st_under, 0);
    chk("R12 int_stat", int_stat, 3'b110); chk("R12 irq", irq, 0);
    chk("R12 valid", smp_valid, 0);

    // R1 R2 R3 vectors
    for (int v = 0; v < 7; v++) begin
      string tag;
      tag = !VEC[v].ctl[5] ? "R1" : (VEC[v].ctl[4:3] == 2'd1 || VEC[v].ctl[4:3] == 2'd2) ? "R3" : "R2";
      restart();
      wr(3'd0, {26'b0, VEC[v].ctl});
      for (int k = 0; k < int'(VEC[v].n); k++) wr(3'd1, (k % 2) ? VEC[v].w1 : VEC[v].w0);
      wr(3'd0, {26'b0, VEC[v].ctl | 6'd7});
      @(negedge clk);
      chk({tag, " valid"}, smp_valid, 1);
      chk({tag, " left"}, smp_left, VEC[v].l);
      chk({tag, " right"}, smp_right, VEC[v].r);
      set_ready(1); repeat (6) @(posedge clk); #5 smp_ready = 0;
    end

    // R4 R8 R9 full fill and drain
    restart();
    wr(3'd0, 16);
    for (int k = 0; k < 9; k++) wr(3'd1, 32'h100 + k);
    @(negedge clk);
    chk("R8 full", st_full, 1); chk("R8 half", st_half, 0);
    chk("R8 empty", st_empty, 0); chk("R8 under", st_under, 0);
    base = cap_n;
    set_ready(1);
    wr(3'd0, 16 | 7);
    repeat (8) @(negedge clk);
    chk("R4 pair count", cap_n - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7 left order", cap_l[(base + k) % 256], 20'h100 + 2 * k);
      chk("R7 right order", cap_r[(base + k) % 256], 20'h101 + 2 * k);
    end
    chk("R9 empty", st_empty, 1); chk("R9 half", st_half, 1);
    chk("R9 under", st_under, 1); chk("R9 full", st_full, 0);
    chk("R10 int_stat", int_stat, 3'b111);
    wr(3'd2, 1); @(negedge clk); chk("R10 irq underrun", irq, 1);
    wr(3'd3, 1); @(negedge clk);
    chk("R11 under cleared", st_under, 0); chk("R11 irq", irq, 0);
    wr(3'd2, 4); @(negedge clk); chk("R10 irq complete", irq, 1);
    set_ready(0);

    // R5 packed boundary
    restart();
    wr(3'd0, 32);
    for (int k = 0; k < 4; k++) wr(3'd1, 32'h00010000 * (k + 1) + k);
    @(negedge clk);
    chk("R5 full", st_full, 0); chk("R5 half", st_half, 0);
    base = cap_n;
    set_ready(1);
    wr(3'd0, 32 | 7);
    repeat (8) @(negedge clk);
    chk("R5 pair count", cap_n - base, 3);
    chk("R5 last right", cap_r[(base + 2) % 256], 20'h00030);

    // R6 threshold
    restart();
    wr(3'd0, 16 | 7);
    base = cap_n;
    for (int k = 0; k < 3; k++) wr(3'd1, k);
    @(negedge clk);
    chk("R6 below threshold valid", smp_valid, 0);
    chk("R6 below threshold count", cap_n - base, 0);
    wr(3'd1, 3);
    repeat (4) @(negedge clk);
    chk("R6 drained count", cap_n - base, 2);
    chk("R9 empty after threshold drain", st_empty, 1);

    // R6 slot gating
    restart();
    wr(3'd0, 16 | 1);
    base = cap_n;
    for (int k = 0; k < 4; k++) wr(3'd1, k);
    repeat (3) @(negedge clk);
    chk("R6 no slot valid", smp_valid, 0);
    chk("R6 no slot count", cap_n - base, 0);
    wr(3'd0, 16 | 5);
    repeat (4) @(negedge clk);
    chk("R6 slot4 count", cap_n - base, 2);
    set_ready(0);

    // R12 interface disable
    restart();
    wr(3'd0, 16);
    wr(3'd1, 1); wr(3'd1, 2);
    wr(3'd2, 7);
    @(negedge clk);
    chk("R10 irq before disable", irq, 1);
    wr(3'd4, 0);
    @(negedge clk);
    chk("R12 disable empty", st_empty, 1); chk("R12 disable half", st_half, 1);
    chk("R12 disable irq", irq, 0);
    wr(3'd4, 1);
    set_ready(1);
    base = cap_n;
    for (int k = 0; k < 4; k++) wr(3'd1, k);
    repeat (3) @(negedge clk);
    chk("R12 control cleared", cap_n - base, 0);
    chk("R12 control cleared valid", smp_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule